// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table held in memory, with 4 KiB pages. The address splits into three fields. Bits [31:22] pick a word in the top-level table, and the location of that table comes from a root pointer supplied with the request. That word, once valid, points at a second-level table. Bits [21:12] pick a word in the second-level table, and that word holds the page frame. The physical address is the frame joined to the untouched 12-bit page offset.

A client presents a virtual address and root pointer on a valid/ready handshake. The walker then issues at most two reads on a single synchronous memory read port, waiting for each read's data-valid, and returns either a translated address with its access rights or a fault that names the level at which the walk stopped. Every table word is 32 bits. Bit 0 is the valid flag, bits [3:1] are the read/write/execute rights, and bits [31:12] are the frame number or the base of the next table. Bits [11:4] are ignored.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker reports `req_ready`=1, `resp_valid`=0 and `mem_rd_en`=0.
- R2: The cycle after a request is accepted, `mem_rd_en` is high with `mem_rd_addr` = {root[31:12], vaddr[31:22], 2'b00}. Root bits [11:0] are ignored.
- R3: After a valid top-level word W arrives, the second read goes to {W[31:12], vaddr[21:12], 2'b00}.
- R4: `mem_rd_en` is a one-cycle pulse per table read. The walker issues no further read while it waits any number of cycles for `mem_rd_valid`.
- R5: When both words are valid, the response carries `resp_paddr` = {inner[31:12], vaddr[11:0]}, `resp_perm` = inner[3:1], `resp_fault`=0 and `resp_fault_level`=0.
- R6: A top-level word with bit 0 clear ends the walk with `resp_fault`=1 and `resp_fault_level`=0 (outer). No second read is issued, and no read is issued while the response is pending.
- R7: A second-level word with bit 0 clear gives `resp_fault`=1 and `resp_fault_level`=1 (inner).
- R8: The response stays valid and unchanged until `resp_ready` is seen. `req_ready` is low from acceptance until the response is taken, and high again the following cycle.
- R9: On any fault, `resp_paddr` and `resp_perm` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Top-level table base (bits [31:12] used) |
| resp_valid | output | 1 | Result available |
| resp_ready | input | 1 | Client takes the result |
| resp_paddr | output | 32 | Translated physical address |
| resp_perm | output | 3 | Access rights from the second-level word |
| resp_fault | output | 1 | Walk failed on an invalid word |
| resp_fault_level | output | 1 | 0 = top level failed, 1 = second level failed |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 32 | Table word returned |

## Verification
The hardest situation to reach from the ports is a read that stays outstanding for many cycles while the client also holds off taking the response. In that window a faulty walker can issue a second strobe or read after a fault without any change in the final answer. The bench models memory as a responder that returns per-walk words after a randomly chosen and sometimes long delay. It delays `resp_ready` by a random number of cycles, and during both waits it checks the read strobe and the stability of the response. Random valid bits, set invalid about one time in five at each level, mix faults at both levels into ordinary walks. Directed cases add all-ones indices and a root pointer with nonzero low bits.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned PERM_W  = 3;
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned RSVD_W  = OFF_W - PERM_W - 1;
  localparam int unsigned HI_LSB  = OFF_W + IDX_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OUT_REQ, ST_OUT_WAIT, ST_IN_REQ, ST_IN_WAIT, ST_RESP
  } walk_st_e;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic [RSVD_W-1:0]  rsvd;
    logic [PERM_W-1:0]  perm;
    logic               valid;
  } pte_t;

  localparam logic LVL_OUTER = 1'b0;
  localparam logic LVL_INNER = 1'b1;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walker_pkg::*;
(
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic               sel_inner,
  output logic [ADDR_W-1:0]  word_addr
);
  localparam int unsigned BYTE_SH = 2;

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] idx_off;

  always_comb begin
    idx      = sel_inner ? vaddr[OFF_W +: IDX_W] : vaddr[HI_LSB +: IDX_W];
    tbl_base = {tbl_frame, {OFF_W{1'b0}}};
    idx_off  = ADDR_W'(idx) << BYTE_SH;
    word_addr = tbl_base + idx_off;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     rd_valid,
  input  logic     pte_ok,
  input  logic     resp_ready,
  output walk_st_e state
);
  walk_st_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     if (req_valid) state_nx = ST_OUT_REQ;
      ST_OUT_REQ:  state_nx = ST_OUT_WAIT;
      ST_OUT_WAIT: if (rd_valid) state_nx = pte_ok ? ST_IN_REQ : ST_RESP;
      ST_IN_REQ:   state_nx = ST_IN_WAIT;
      ST_IN_WAIT:  if (rd_valid) state_nx = ST_RESP;
      ST_RESP:     if (resp_ready) state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic [31:0]       req_root,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [31:0]       resp_paddr,
  output logic [2:0]        resp_perm,
  output logic              resp_fault,
  output logic              resp_fault_level,
  output logic              mem_rd_en,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data
);
  walk_st_e           state;
  pte_t               rd_pte;
  logic [ADDR_W-1:0]  va_q;
  logic [FRAME_W-1:0] base_q;
  logic               accept, out_ret, in_ret;
  logic               va_en, base_en, res_en;
  logic [FRAME_W-1:0] base_d;
  logic [ADDR_W-1:0]  paddr_d;
  logic [PERM_W-1:0]  perm_d;
  logic               fault_d, lvl_d;
  logic               unused_bits;

  assign rd_pte      = pte_t'(mem_rd_data);
  assign unused_bits = ^{req_root[OFF_W-1:0], rd_pte.rsvd};

  pt_walk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rd_valid   (mem_rd_valid),
    .pte_ok     (rd_pte.valid),
    .resp_ready (resp_ready),
    .state      (state)
  );

  pt_addr_gen u_addr (
    .tbl_frame (base_q),
    .vaddr     (va_q),
    .sel_inner (state == ST_IN_REQ),
    .word_addr (mem_rd_addr)
  );

  always_comb begin
    accept  = (state == ST_IDLE) && req_valid;
    out_ret = (state == ST_OUT_WAIT) && mem_rd_valid;
    in_ret  = (state == ST_IN_WAIT) && mem_rd_valid;
    va_en   = accept;
    base_en = accept || (out_ret && rd_pte.valid);
    base_d  = accept ? req_root[ADDR_W-1:OFF_W] : rd_pte.frame;
    res_en  = (out_ret && !rd_pte.valid) || in_ret;
    if (in_ret && rd_pte.valid) begin
      paddr_d = {rd_pte.frame, va_q[OFF_W-1:0]};
      perm_d  = rd_pte.perm;
      fault_d = 1'b0;
      lvl_d   = LVL_OUTER;
    end else begin
      paddr_d = '0;
      perm_d  = '0;
      fault_d = 1'b1;
      lvl_d   = in_ret ? LVL_INNER : LVL_OUTER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
    end else begin
      if (va_en)   va_q   <= req_vaddr;
      if (base_en) base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_paddr       <= '0;
      resp_perm        <= '0;
      resp_fault       <= 1'b0;
      resp_fault_level <= 1'b0;
    end else if (res_en) begin
      resp_paddr       <= paddr_d;
      resp_perm        <= perm_d;
      resp_fault       <= fault_d;
      resp_fault_level <= lvl_d;
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign resp_valid = (state == ST_RESP);
  assign mem_rd_en  = (state == ST_OUT_REQ) || (state == ST_IN_REQ);
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic        resp_valid,
  input logic        resp_ready,
  input logic [31:0] resp_paddr,
  input logic [2:0]  resp_perm,
  input logic        resp_fault,
  input logic        resp_fault_level,
  input logic        mem_rd_en,
  input logic [31:0] mem_rd_addr
);
  logic [31:0] va_seen;
  logic [1:0]  rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_seen <= '0;
      rd_cnt  <= '0;
    end else if (req_valid && req_ready) begin
      va_seen <= req_vaddr;
      rd_cnt  <= '0;
    end else if (mem_rd_en && rd_cnt != 2'd3) begin
      rd_cnt  <= rd_cnt + 2'd1;
    end
  end

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  assert_outer_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && rd_cnt == 2'd0) |-> mem_rd_addr[11:0] == {va_seen[31:22], 2'b00});
  assert_inner_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && rd_cnt == 2'd1) |-> mem_rd_addr[11:0] == {va_seen[21:12], 2'b00});
  assert_read_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> rd_cnt < 2'd2);
  assert_outer_fault_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault && !resp_fault_level) |-> (rd_cnt == 2'd1 && !mem_rd_en));
  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> resp_paddr[11:0] == va_seen[11:0]);
  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_paddr == 32'd0 && resp_perm == 3'd0));
  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr) &&
      $stable(resp_perm) && $stable(resp_fault) && $stable(resp_fault_level)));
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr, req_root;
  logic        resp_valid, resp_ready;
  logic [31:0] resp_paddr;
  logic [2:0]  resp_perm;
  logic        resp_fault, resp_fault_level;
  logic        mem_rd_en, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  pt_walker dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_outer(input logic [31:0] root, input logic [31:0] va);
    return {root[31:12], va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] exp_inner(input logic [31:0] ow, input logic [31:0] va);
    return {ow[31:12], va[21:12], 2'b00};
  endfunction
  function automatic logic [31:0] exp_paddr(input logic [31:0] iw, input logic [31:0] va);
    return {iw[31:12], va[11:0]};
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] root, input logic [31:0] ow,
                      input logic [31:0] iw, input int d0, input int d1, input int hold);
    int nrd = 0;
    int t = 0;
    bit efault = !ow[0] || !iw[0];
    logic [31:0] epa, snap;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_root = root;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = $urandom; req_root = $urandom;
    chk(req_ready == 1'b0, "R8 busy", {31'd0, req_ready}, 32'd0);
    while (!resp_valid && t < 400) begin
      if (mem_rd_en) begin
        if (nrd == 0) chk(mem_rd_addr == exp_outer(root, va), "R2 outer addr", mem_rd_addr, exp_outer(root, va));
        else          chk(mem_rd_addr == exp_inner(ow, va), "R3 inner addr", mem_rd_addr, exp_inner(ow, va));
        @(negedge clk);
        for (int k = 0; k < (nrd == 0 ? d0 : d1); k++) begin
          chk(!mem_rd_en, "R4 no read while waiting", {31'd0, mem_rd_en}, 32'd0);
          @(negedge clk);
        end
        mem_rd_valid = 1'b1;
        mem_rd_data  = (nrd == 0) ? ow : iw;
        nrd++;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        mem_rd_data  = $urandom;
      end else begin
        @(negedge clk);
        t++;
      end
    end
    chk(resp_valid, "R5 response arrives", {31'd0, resp_valid}, 32'd1);
    if (!ow[0]) begin
      chk(nrd == 1, "R6 single read on outer fault", nrd, 1);
      chk(resp_fault && !resp_fault_level, "R6 outer fault", {30'd0, resp_fault, resp_fault_level}, 32'd2);
    end else begin
      chk(nrd == 2, "R3 two reads", nrd, 2);
      if (!iw[0])
        chk(resp_fault && resp_fault_level, "R7 inner fault", {30'd0, resp_fault, resp_fault_level}, 32'd3);
    end
    if (efault) begin
      chk(resp_paddr == 0 && resp_perm == 0, "R9 zero on fault", resp_paddr | {29'd0, resp_perm}, 32'd0);
    end else begin
      epa = exp_paddr(iw, va);
      chk(resp_paddr == epa, "R5 paddr", resp_paddr, epa);
      chk(resp_perm == iw[3:1], "R5 perm", {29'd0, resp_perm}, {29'd0, iw[3:1]});
      chk(!resp_fault && !resp_fault_level, "R5 no fault", {30'd0, resp_fault, resp_fault_level}, 32'd0);
    end
    snap = resp_paddr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(resp_valid && resp_paddr == snap, "R8 hold", resp_paddr, snap);
      chk(!mem_rd_en, "R6 no read while response pending", {31'd0, mem_rd_en}, 32'd0);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(!resp_valid && req_ready, "R8 released", {30'd0, resp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    logic [31:0] ow, iw;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_root = '0;
    resp_ready = 1'b0; mem_rd_valid = 1'b0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_rd_en, "R1 reset state",
        {29'd0, req_ready, resp_valid, mem_rd_en}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_rd_en, "R1 after release",
        {29'd0, req_ready, resp_valid, mem_rd_en}, 32'd4);

    walk(32'hFFFF_FFFF, 32'h1234_5FFF, 32'hABCD_E00F, 32'h0F0F_1FFB, 0, 0, 0);
    walk(32'h0000_0000, 32'h0000_0ABC, 32'h0000_1001, 32'h0000_200D, 20, 15, 6);
    walk(32'h0040_3005, 32'h8000_0000, 32'h4444_4000, 32'h5555_5003, 1, 2, 1);
    walk(32'hC030_0ABC, 32'h0001_0000, 32'h0002_0001, 32'h0003_0000, 3, 0, 2);
    walk(32'h7FC0_1234, 32'h0ACE_0000, 32'h9999_90FF, 32'h7777_7007, 5, 5, 3);

    for (int n = 0; n < 120; n++) begin
      ow = $urandom; ow[0] = ($urandom % 5) != 0;
      iw = $urandom; iw[0] = ($urandom % 5) != 0;
      walk($urandom, $urandom, ow, iw, $urandom % 6, $urandom % 6, $urandom % 4);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule